// File: doc/BRIEF.md
# Vector Shift and Shuffle Unit

This block rearranges data between two 512-bit vector operands and returns one 512-bit vector. An operation code chooses between a byte-granular right shift across the concatenated operand pair, a scalar push that feeds an 8-, 16- or 32-bit value in at one end of the vector while the element at the other end falls off, and interleave or deinterleave of the two operands at 8-, 16- or 32-bit element size. The interleave and deinterleave paths form a 1024-bit intermediate, and a select input picks its lower or upper 512 bits.

A request is presented with `in_valid` high for one cycle. The result appears on `result` one clock later, with `out_valid` high in that cycle. The result register keeps its value while no request arrives. The block holds no other state, and it has no back-pressure.

Top module: `vshuf_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and the matching result is on `result` in that same cycle (latency of one clock).
- R2: While `rst` is high, and in the first cycle after it is released, `out_valid` is 0 and `result` is all zeros.
- R3: When `in_valid` is low, `result` keeps its previous value.
- R4: With `op` = 0 (right shift), result byte i equals byte i+`shamt` of the 1024-bit value {`b`,`a`}. Here `a` holds bytes 0..63 and `b` holds bytes 64..127, and `shamt` ranges over 0..63.
- R5: With `op` = 1 (push low), the low element of width W takes `scalar[W-1:0]`. Every other element of `a` moves up one W-bit position, and the top W bits of `a` are discarded.
- R6: With `op` = 2 (push high), the top W bits of the result take `scalar[W-1:0]`. Every other element of `a` moves down one W-bit position, and the low W bits of `a` are discarded.
- R7: With `op` = 3 (interleave), the 1024-bit intermediate holds a0,b0,a1,b1,… from element 0 upward. `hi_sel` = 0 returns its lower 512 bits and `hi_sel` = 1 returns its upper 512 bits.
- R8: With `op` = 4 (deinterleave), let c be the 2N elements of {`b`,`a`}, with `a` holding elements 0..N-1. The intermediate holds all even-indexed c elements in order, followed by all odd-indexed ones. `hi_sel` selects the half as in R7.
- R9: `elsz` sets the element width W for ops 1..4: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits.
- R10: The reserved `op` codes 5, 6 and 7 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 shift, 1 push low, 2 push high, 3 interleave, 4 deinterleave) |
| elsz | input | 2 | Element width code |
| shamt | input | 6 | Right shift in bytes |
| hi_sel | input | 1 | Selects upper half of the interleave/deinterleave intermediate |
| scalar | input | 32 | Value pushed by ops 1 and 2 |
| a | input | 512 | First vector operand |
| b | input | 512 | Second vector operand |
| out_valid | output | 1 | Result strobe |
| result | output | 512 | Registered result vector |

## Verification
The assertions assume that every input is a known value whenever `in_valid` is high. They also assume that `op`, `elsz` and the operands are held steady only for the request cycle, because each check compares `result` with the inputs sampled one edge earlier. The bench drives all inputs on the falling edge, so each request lasts one full clock. It lowers `in_valid` between most requests, which lets the hold property see idle cycles in which `a` and `b` change. The operand patterns come from a per-vector seed, so neighbouring bytes and elements always differ and any misplaced lane shows up in the result.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;

    localparam int VEC_W    = 512;
    localparam int SCALAR_W = 32;
    localparam int BYTES    = VEC_W / 8;
    localparam int SHAMT_W  = $clog2(BYTES);
    localparam int N_SIZES  = 3;
    localparam int OP_W     = 3;
    localparam int ESZ_W    = 2;

    typedef enum logic [OP_W-1:0] {
        OP_SHR     = 3'd0,
        OP_PUSH_LO = 3'd1,
        OP_PUSH_HI = 3'd2,
        OP_ILV     = 3'd3,
        OP_DLV     = 3'd4
    } vop_e;

    typedef enum logic [ESZ_W-1:0] {
        ES_8   = 2'd0,
        ES_16  = 2'd1,
        ES_32  = 2'd2,
        ES_32X = 2'd3
    } esz_e;

    typedef struct packed {
        logic [VEC_W-1:0] ilv;
        logic [VEC_W-1:0] dlv;
    } weave_t;

    typedef struct packed {
        logic [VEC_W-1:0] shr;
        logic [VEC_W-1:0] plo;
        logic [VEC_W-1:0] phi;
    } shift_t;

    // Index of the size variant: 0 -> 8 bit, 1 -> 16 bit, 2 -> 32 bit.
    function automatic logic [1:0] size_idx(input logic [ESZ_W-1:0] e);
        case (esz_e'(e))
            ES_8:    return 2'd0;
            ES_16:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/vshuf_shift.sv
module vshuf_shift
    import vshuf_pkg::*;
(
    input  logic [VEC_W-1:0]    a,
    input  logic [VEC_W-1:0]    b,
    input  logic [SHAMT_W-1:0]  shamt,
    input  logic [SCALAR_W-1:0] scalar,
    input  logic [ESZ_W-1:0]    elsz,
    output shift_t              res
);

    logic [2*VEC_W-1:0] pair;
    logic [2*VEC_W-1:0] pair_sh;
    logic [VEC_W-1:0]   plo_v [N_SIZES];
    logic [VEC_W-1:0]   phi_v [N_SIZES];

    assign pair    = {b, a};
    assign pair_sh = pair >> {shamt, 3'b000};

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int W = 8 << g;
        assign plo_v[g] = {a[VEC_W-1-W:0], scalar[W-1:0]};
        assign phi_v[g] = {scalar[W-1:0], a[VEC_W-1:W]};
    end

    always_comb begin
        res.shr = pair_sh[VEC_W-1:0];
        res.plo = plo_v[size_idx(elsz)];
        res.phi = phi_v[size_idx(elsz)];
    end

endmodule

// File: rtl/vshuf_weave.sv
module vshuf_weave
    import vshuf_pkg::*;
(
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [ESZ_W-1:0] elsz,
    input  logic             hi_sel,
    output weave_t           res
);

    logic [2*VEC_W-1:0] ilv_full [N_SIZES];
    logic [2*VEC_W-1:0] dlv_full [N_SIZES];
    logic [2*VEC_W-1:0] pair;
    logic [2*VEC_W-1:0] ilv_sel;
    logic [2*VEC_W-1:0] dlv_sel;

    assign pair = {b, a};

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int W = 8 << g;
        localparam int N = VEC_W / W;
        for (genvar k = 0; k < N; k++) begin : g_elem
            // interleave: a_k to slot 2k, b_k to slot 2k+1
            assign ilv_full[g][(2*k)*W   +: W] = a[k*W +: W];
            assign ilv_full[g][(2*k+1)*W +: W] = b[k*W +: W];
            // deinterleave: even elements low, odd elements high
            assign dlv_full[g][k*W     +: W] = pair[(2*k)*W   +: W];
            assign dlv_full[g][(N+k)*W +: W] = pair[(2*k+1)*W +: W];
        end
    end

    always_comb begin
        ilv_sel = ilv_full[size_idx(elsz)];
        dlv_sel = dlv_full[size_idx(elsz)];
        res.ilv = hi_sel ? ilv_sel[2*VEC_W-1:VEC_W] : ilv_sel[VEC_W-1:0];
        res.dlv = hi_sel ? dlv_sel[2*VEC_W-1:VEC_W] : dlv_sel[VEC_W-1:0];
    end

endmodule

// File: rtl/vshuf_unit.sv
module vshuf_unit
    import vshuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [1:0]          elsz,
    input  logic [5:0]          shamt,
    input  logic                hi_sel,
    input  logic [31:0]         scalar,
    input  logic [511:0]        a,
    input  logic [511:0]        b,
    output logic                out_valid,
    output logic [511:0]        result
);

    shift_t           sh_res;
    weave_t           wv_res;
    logic [VEC_W-1:0] nxt;

    vshuf_shift shift_i (
        .a      (a),
        .b      (b),
        .shamt  (shamt),
        .scalar (scalar),
        .elsz   (elsz),
        .res    (sh_res)
    );

    vshuf_weave weave_i (
        .a      (a),
        .b      (b),
        .elsz   (elsz),
        .hi_sel (hi_sel),
        .res    (wv_res)
    );

    always_comb begin
        case (vop_e'(op))
            OP_SHR:     nxt = sh_res.shr;
            OP_PUSH_LO: nxt = sh_res.plo;
            OP_PUSH_HI: nxt = sh_res.phi;
            OP_ILV:     nxt = wv_res.ilv;
            OP_DLV:     nxt = wv_res.dlv;
            default:    nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt;
            end
        end
    end

endmodule

// File: rtl/vshuf_chk.sv
module vshuf_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [2:0]   op,
    input logic [1:0]   elsz,
    input logic [5:0]   shamt,
    input logic         hi_sel,
    input logic [31:0]  scalar,
    input logic [511:0] a,
    input logic [7:0]   b_lo,
    input logic         out_valid,
    input logic [511:0] result
);

    // R2
    a_r2_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R1
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R4
    a_r4_shift_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0 && shamt == 6'd0) |=> (result == $past(a)));

    // R5
    a_r5_push_lo_byte: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd1 && elsz == 2'd0) |=>
        (result[7:0] == $past(scalar[7:0]) && result[511:8] == $past(a[503:0])));

    // R6
    a_r6_push_hi_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd2 && elsz == 2'd2) |=>
        (result[511:480] == $past(scalar) && result[479:0] == $past(a[511:32])));

    // R7
    a_r7_ilv_lo_byte: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3 && elsz == 2'd0 && !hi_sel) |=>
        (result[15:0] == {$past(b_lo), $past(a[7:0])}));

    // R8
    a_r8_dlv_lo_byte: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4 && elsz == 2'd0 && !hi_sel) |=>
        (result[15:0] == {$past(a[23:16]), $past(a[7:0])}));

    // R10
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 3'd5) |=> (result == '0));

endmodule

bind vshuf_unit vshuf_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .elsz      (elsz),
    .shamt     (shamt),
    .hi_sel    (hi_sel),
    .scalar    (scalar),
    .a         (a),
    .b_lo      (b[7:0]),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/vshuf_unit_tb_top.sv
module vshuf_unit_tb_top;

    localparam time CLK_P = 20ns;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   op;
    logic [1:0]   elsz;
    logic [5:0]   shamt;
    logic         hi_sel;
    logic [31:0]  scalar;
    logic [511:0] a;
    logic [511:0] b;
    logic         out_valid;
    logic [511:0] result;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    vshuf_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .elsz(elsz),
        .shamt(shamt), .hi_sel(hi_sel), .scalar(scalar), .a(a), .b(b),
        .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  esz;
        logic [5:0]  sh;
        logic        hi;
        logic [31:0] scal;
        logic [7:0]  seed;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 2'd0, 6'd0,  1'b0, 32'h0,        8'd1,  4'd4},
        '{3'd0, 2'd0, 6'd5,  1'b0, 32'h0,        8'd2,  4'd4},
        '{3'd0, 2'd0, 6'd37, 1'b0, 32'h0,        8'd3,  4'd4},
        '{3'd1, 2'd0, 6'd0,  1'b0, 32'hA1B2C3D4, 8'd4,  4'd5},
        '{3'd1, 2'd1, 6'd0,  1'b0, 32'h11223344, 8'd5,  4'd5},
        '{3'd1, 2'd2, 6'd0,  1'b0, 32'hDEADBEEF, 8'd6,  4'd5},
        '{3'd2, 2'd0, 6'd0,  1'b0, 32'h55667788, 8'd7,  4'd6},
        '{3'd2, 2'd1, 6'd0,  1'b0, 32'h99AABBCC, 8'd8,  4'd6},
        '{3'd2, 2'd2, 6'd0,  1'b0, 32'h0BADF00D, 8'd9,  4'd6},
        '{3'd3, 2'd0, 6'd0,  1'b0, 32'h0,        8'd10, 4'd7},
        '{3'd3, 2'd1, 6'd0,  1'b1, 32'h0,        8'd11, 4'd7},
        '{3'd3, 2'd2, 6'd0,  1'b1, 32'h0,        8'd12, 4'd7},
        '{3'd4, 2'd0, 6'd0,  1'b0, 32'h0,        8'd13, 4'd8},
        '{3'd4, 2'd0, 6'd0,  1'b1, 32'h0,        8'd14, 4'd8},
        '{3'd4, 2'd1, 6'd0,  1'b1, 32'h0,        8'd15, 4'd8},
        '{3'd4, 2'd2, 6'd0,  1'b0, 32'h0,        8'd16, 4'd8}
    };

    function automatic logic [511:0] gen_a(input logic [7:0] s);
        logic [511:0] v;
        for (int i = 0; i < 64; i++) v[8*i +: 8] = 8'(s * 7 + i * 3 + 1);
        return v;
    endfunction

    function automatic logic [511:0] gen_b(input logic [7:0] s);
        logic [511:0] v;
        for (int i = 0; i < 64; i++) v[8*i +: 8] = 8'(s * 5 + i * 11 + 8'h80);
        return v;
    endfunction

    // Reference model, built per byte / element from the requirements.
    function automatic logic [511:0] model(input logic [2:0] mop, input logic [1:0] mes,
                                           input logic [5:0] msh, input logic mhi,
                                           input logic [31:0] msc,
                                           input logic [511:0] ma, input logic [511:0] mb);
        logic [511:0] r;
        int wb, ne, gidx, src;
        logic [1023:0] c;
        r  = '0;
        c  = {mb, ma};
        wb = (mes == 2'd0) ? 1 : (mes == 2'd1) ? 2 : 4;   // R9
        ne = 64 / wb;
        case (mop)
            3'd0: for (int i = 0; i < 64; i++) r[8*i +: 8] = c[8*(i + msh) +: 8];
            3'd1: for (int i = 0; i < 64; i++)
                      r[8*i +: 8] = (i < wb) ? msc[8*i +: 8] : ma[8*(i - wb) +: 8];
            3'd2: for (int i = 0; i < 64; i++)
                      r[8*i +: 8] = (i >= 64 - wb) ? msc[8*(i - 64 + wb) +: 8]
                                                   : ma[8*(i + wb) +: 8];
            3'd3: for (int e = 0; e < ne; e++) begin
                      gidx = e + (mhi ? ne : 0);
                      src  = gidx / 2;
                      for (int k = 0; k < wb; k++)
                          r[8*(e*wb + k) +: 8] = (gidx % 2 == 0) ? ma[8*(src*wb + k) +: 8]
                                                                 : mb[8*(src*wb + k) +: 8];
                  end
            3'd4: for (int e = 0; e < ne; e++) begin
                      gidx = e + (mhi ? ne : 0);
                      src  = (gidx < ne) ? 2 * gidx : 2 * (gidx - ne) + 1;
                      for (int k = 0; k < wb; k++)
                          r[8*(e*wb + k) +: 8] = c[8*(src*wb + k) +: 8];
                  end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [511:0] got, input logic [511:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: result=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // Drive one request at a falling edge; sample one clock later.
    task automatic issue(input logic [2:0] o, input logic [1:0] e, input logic [5:0] s,
                         input logic h, input logic [31:0] sc,
                         input logic [511:0] va, input logic [511:0] vb);
        @(negedge clk);
        in_valid = 1'b1; op = o; elsz = e; shamt = s; hi_sel = h; scalar = sc; a = va; b = vb;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd4:    return "R4 shift";
            4'd5:    return "R5 push low";
            4'd6:    return "R6 push high";
            4'd7:    return "R7 interleave";
            default: return "R8 deinterleave";
        endcase
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [511:0] exp, held;
        rst = 1'b1; in_valid = 1'b0; op = '0; elsz = '0; shamt = '0; hi_sel = 1'b0;
        scalar = '0; a = gen_a(8'd99); b = gen_b(8'd99);
        repeat (3) @(negedge clk);
        // R2: reset state
        check_bit("R2 out_valid in reset", out_valid, 1'b0);
        check_vec("R2 result in reset", result, '0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R2 out_valid after reset", out_valid, 1'b0);
        check_vec("R2 result after reset", result, '0);

        // Table walk: R4..R9 with several element sizes and halves
        for (int t = 0; t < NV; t++) begin
            issue(TBL[t].op, TBL[t].esz, TBL[t].sh, TBL[t].hi, TBL[t].scal,
                  gen_a(TBL[t].seed), gen_b(TBL[t].seed));
            exp = model(TBL[t].op, TBL[t].esz, TBL[t].sh, TBL[t].hi, TBL[t].scal,
                        gen_a(TBL[t].seed), gen_b(TBL[t].seed));
            check_vec(rtag(TBL[t].req), result, exp);
            check_bit("R1 out_valid with result", out_valid, 1'b1);
        end

        // R4 boundary: maximum shift of 63 bytes
        issue(3'd0, 2'd0, 6'd63, 1'b0, 32'h0, gen_a(8'd40), gen_b(8'd40));
        check_vec("R4 shift 63", result,
                  model(3'd0, 2'd0, 6'd63, 1'b0, 32'h0, gen_a(8'd40), gen_b(8'd40)));

        // R9: code 3 acts as 32-bit for push and interleave
        issue(3'd1, 2'd3, 6'd0, 1'b0, 32'hCAFEF00D, gen_a(8'd41), gen_b(8'd41));
        check_vec("R9 size code 3 push", result,
                  model(3'd1, 2'd2, 6'd0, 1'b0, 32'hCAFEF00D, gen_a(8'd41), gen_b(8'd41)));
        issue(3'd3, 2'd3, 6'd0, 1'b0, 32'h0, gen_a(8'd42), gen_b(8'd42));
        check_vec("R9 size code 3 interleave", result,
                  model(3'd3, 2'd2, 6'd0, 1'b0, 32'h0, gen_a(8'd42), gen_b(8'd42)));

        // R3: result held over idle cycles while inputs change
        held = result;
        @(negedge clk);
        op = 3'd2; a = gen_a(8'd77); b = gen_b(8'd77); scalar = 32'h12345678;
        @(negedge clk);
        @(negedge clk);
        check_vec("R3 hold while idle", result, held);
        check_bit("R1 out_valid low while idle", out_valid, 1'b0);

        // R10: reserved op codes give zero
        for (int o = 5; o < 8; o++) begin
            issue(3'(o), 2'd0, 6'd9, 1'b1, 32'hFFFFFFFF, gen_a(8'd50), gen_b(8'd50));
            check_vec("R10 reserved op", result, '0);
        end

        // R1: back-to-back requests each land one clock later
        @(negedge clk);
        in_valid = 1'b1; op = 3'd2; elsz = 2'd1; shamt = '0; hi_sel = 1'b0;
        scalar = 32'h0000ABCD; a = gen_a(8'd60); b = gen_b(8'd60);
        @(negedge clk);
        check_vec("R1 back-to-back first", result,
                  model(3'd2, 2'd1, 6'd0, 1'b0, 32'h0000ABCD, gen_a(8'd60), gen_b(8'd60)));
        op = 3'd4; elsz = 2'd1; hi_sel = 1'b0; a = gen_a(8'd61); b = gen_b(8'd61);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec("R1 back-to-back second", result,
                  model(3'd4, 2'd1, 6'd0, 1'b0, 32'h0, gen_a(8'd61), gen_b(8'd61)));
        check_bit("R1 out_valid second", out_valid, 1'b1);

        // R2: reset mid-run clears the output
        rst = 1'b1;
        @(negedge clk);
        check_vec("R2 result cleared by reset", result, '0);
        rst = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule